// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is an on-chip word memory with a fixed-latency pipeline. A command is made up of an address, a direction flag, per-byte write enables and three select inputs. The command is registered on a rising clock edge. Its data beat lands on the second enabled edge after that, for reads and for writes alike. Because both directions use the same delay, a stream of commands can mix reads and writes in any order with no idle slots between them.

The controlling agent has three further controls:

- A load/advance input starts a new access from the address pins. It can instead step an internal two-bit beat counter, which gives up to four beats from one loaded address, in either linear or interleaved order.
- A clock-enable input freezes the whole pipeline while it is low.
- An asynchronous output enable can mask the read-data qualifier at any moment.

Data in, data out and the output-drive qualifier are separate signals, in place of a bidirectional pad.

Top module: `zbt_sram`

## Requirements
- R1: A read command accepted on an enabled edge puts the word at its address on `dout`, with `dout_oe` high, right after the second enabled edge that follows.
- R2: For a write command, `din` is taken on the second enabled edge after the command. Only the lanes whose `byte_we` bit is 1 are written; bit i covers `din[8i+7:8i]`.
- R3: Reads and writes can alternate on consecutive edges with no idle slot. A read issued two edges after a write to the same address returns the newly written word.
- R4: While `cke` is 0, every other synchronous input is ignored. `dout` and `dout_oe` keep their values, no write takes place, and the burst state does not move.
- R5: A new access starts only when `adv` is 0, `cs_n_a` is 0, `cs_b` is 1 and `cs_n_c` is 0. With `adv` 0 and any select inactive, the slot is idle. With `adv` 1 after an idle slot, the slot stays idle.
- R6: An idle slot does not cancel reads or writes that are already in the pipeline. They complete on their own data beats.
- R7: `dout_oe` goes low after the second enabled edge following an idle slot or a write command.
- R8: With `adv` 1 after an active access, the next beat keeps the loaded direction and the upper address bits. Its low two bits come from a beat counter that advances once per enabled edge and wraps after four beats.
- R9: With `ilv` 0, the low two bits of beat k are (base + k) mod 4, for example 1,2,3,0.
- R10: With `ilv` 1, the low two bits of beat k are base XOR k, for example 1,0,3,2.
- R11: `oe` low forces `dout_oe` low at once. It does not disturb the pipeline: raising `oe` again shows the current read state.
- R12: After reset, `dout_oe` is 0 and the pipeline holds no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of pipeline and burst state |
| cke | input | 1 | Clock enable, 1 = advance the pipeline |
| cs_n_a | input | 1 | Select, active low |
| cs_b | input | 1 | Select, active high |
| cs_n_c | input | 1 | Select, active low |
| adv | input | 1 | 0 = load a new address, 1 = advance the burst |
| wr | input | 1 | 1 = write, 0 = read (used on a load) |
| addr | input | ADDR_W | Word address |
| byte_we | input | NB | Per-lane write enable, sampled with each command |
| ilv | input | 1 | Burst order, 0 = linear, 1 = interleaved |
| din | input | 8*NB | Write data for the beat on this edge |
| oe | input | 1 | Asynchronous output enable |
| dout | output | 8*NB | Read data |
| dout_oe | output | 1 | Read data is being driven |

## Verification
A command lost or duplicated in the two pipeline stages shows up at the ports one or two edges later. It appears as `dout_oe` asserted in a slot where no read is due, or as a write beat that lands on the wrong edge, which the next read of that word exposes. A burst counter that steps wrongly, or ignores the order input, returns a word from the wrong address in the very beat after the fault. A stage that slips during a stall shifts every later beat by one slot, so the reference comparison fails on the next enabled edge.

// File: rtl/zbt_pkg.sv
package zbt_pkg;

  typedef struct packed {
    logic valid;
    logic wr;
  } ctl_t;

  // low two address bits of beat k from a loaded base
  function automatic logic [1:0] beat_lsb(input logic [1:0] base,
                                          input logic [1:0] k,
                                          input logic       ilv);
    logic [1:0] r;
    if (ilv) r = base ^ k;
    else     r = base + k;
    return r;
  endfunction

  // all three selects active
  function automatic logic chip_sel(input logic sa_n, input logic sb, input logic sc_n);
    return (!sa_n) && sb && (!sc_n);
  endfunction

endpackage

// File: rtl/zbt_burst_ctl.sv
module zbt_burst_ctl
  import zbt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NB     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke,
  input  logic              adv,
  input  logic              sel,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NB-1:0]     be_i,
  input  logic              ilv,
  output ctl_t              cmd_ctl,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [NB-1:0]     cmd_be
);

  logic              active_q;
  logic [ADDR_W-1:0] base_q;
  logic [1:0]        beat_q;
  logic              dir_q;
  logic [1:0]        beat_nx;
  logic              load_ev;
  logic              step_ev;

  assign beat_nx = beat_q + 2'd1;
  assign load_ev = cke && !adv;
  assign step_ev = cke && adv && active_q;

  always_comb begin
    cmd_be = be_i;
    if (!adv) begin
      cmd_ctl.valid = sel;
      cmd_ctl.wr    = wr_i;
      cmd_addr      = addr_i;
    end else begin
      cmd_ctl.valid = active_q;
      cmd_ctl.wr    = dir_q;
      cmd_addr      = {base_q[ADDR_W-1:2], beat_lsb(base_q[1:0], beat_nx, ilv)};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      base_q   <= '0;
      beat_q   <= 2'd0;
      dir_q    <= 1'b0;
    end else if (load_ev) begin
      active_q <= sel;
      base_q   <= addr_i;
      beat_q   <= 2'd0;
      dir_q    <= wr_i;
    end else if (step_ev) begin
      beat_q <= beat_nx;
    end
  end

  AST_BEAT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |=> $stable(beat_q) && $stable(active_q)) else $error("burst moved on stall"); // R4

  AST_STEP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    step_ev && beat_q == 2'd3 |=> beat_q == 2'd0) else $error("beat counter no wrap"); // R8

endmodule

// File: rtl/zbt_pipe.sv
module zbt_pipe
  import zbt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NB     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke,
  input  ctl_t              in_ctl,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [NB-1:0]     in_be,
  output ctl_t              s1_ctl,
  output logic [ADDR_W-1:0] s1_addr,
  output ctl_t              s2_ctl,
  output logic [ADDR_W-1:0] s2_addr,
  output logic [NB-1:0]     s2_be
);

  logic [NB-1:0] s1_be;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_ctl  <= '0;
      s2_ctl  <= '0;
      s1_addr <= '0;
      s2_addr <= '0;
      s1_be   <= '0;
      s2_be   <= '0;
    end else if (cke) begin
      s1_ctl  <= in_ctl;
      s1_addr <= in_addr;
      s1_be   <= in_be;
      s2_ctl  <= s1_ctl;
      s2_addr <= s1_addr;
      s2_be   <= s1_be;
    end
  end

  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |=> $stable(s1_ctl) && $stable(s2_ctl) && $stable(s2_addr)) else $error("pipe moved on stall"); // R4

  AST_SLOT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    cke && s1_ctl.valid |=> s2_ctl.valid) else $error("access lost between stages"); // R6

endmodule

// File: rtl/zbt_array.sv
module zbt_array #(
  parameter int ADDR_W = 8,
  parameter int NB     = 2
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NB-1:0]     be,
  input  logic [8*NB-1:0]   wdata,
  output logic [8*NB-1:0]   rdata
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int DW    = 8 * NB;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] lane_mask;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign lane_mask[8*g +: 8] = {8{be[g]}};
  end

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= (mem[addr] & ~lane_mask) | (wdata & lane_mask);
  end

  assign rdata = mem[addr];

endmodule

// File: rtl/zbt_sram.sv
module zbt_sram
  import zbt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NB     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke,
  input  logic              cs_n_a,
  input  logic              cs_b,
  input  logic              cs_n_c,
  input  logic              adv,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NB-1:0]     byte_we,
  input  logic              ilv,
  input  logic [8*NB-1:0]   din,
  input  logic              oe,
  output logic [8*NB-1:0]   dout,
  output logic              dout_oe
);

  localparam int DW = 8 * NB;

  ctl_t              cmd_ctl, s1_ctl, s2_ctl;
  logic [ADDR_W-1:0] cmd_addr, s1_addr, s2_addr;
  logic [NB-1:0]     cmd_be, s2_be;
  logic [DW-1:0]     arr_rdata;
  logic              sel;
  logic              wr_beat;
  logic              rd_beat;
  logic              rd_en_q;
  logic [DW-1:0]     dout_q;

  assign sel     = chip_sel(cs_n_a, cs_b, cs_n_c);
  assign wr_beat = cke && s2_ctl.valid && s2_ctl.wr;
  assign rd_beat = cke && s2_ctl.valid && !s2_ctl.wr;

  zbt_burst_ctl #(.ADDR_W(ADDR_W), .NB(NB)) u_burst (
    .clk(clk), .rst_n(rst_n), .cke(cke), .adv(adv), .sel(sel), .wr_i(wr),
    .addr_i(addr), .be_i(byte_we), .ilv(ilv),
    .cmd_ctl(cmd_ctl), .cmd_addr(cmd_addr), .cmd_be(cmd_be)
  );

  zbt_pipe #(.ADDR_W(ADDR_W), .NB(NB)) u_pipe (
    .clk(clk), .rst_n(rst_n), .cke(cke),
    .in_ctl(cmd_ctl), .in_addr(cmd_addr), .in_be(cmd_be),
    .s1_ctl(s1_ctl), .s1_addr(s1_addr),
    .s2_ctl(s2_ctl), .s2_addr(s2_addr), .s2_be(s2_be)
  );

  zbt_array #(.ADDR_W(ADDR_W), .NB(NB)) u_array (
    .clk(clk), .we(wr_beat), .addr(s2_addr), .be(s2_be),
    .wdata(din), .rdata(arr_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_en_q <= 1'b0;
      dout_q  <= '0;
    end else if (cke) begin
      rd_en_q <= rd_beat;
      if (rd_beat) dout_q <= arr_rdata;
    end
  end

  assign dout    = dout_q;
  assign dout_oe = rd_en_q && oe;

  AST_READ_TWO_LATER: assert property (@(posedge clk) disable iff (!rst_n)
    cke && s2_ctl.valid && !s2_ctl.wr |=> rd_en_q) else $error("read beat missing"); // R1

  AST_WRITE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    cke && !(s2_ctl.valid && !s2_ctl.wr) |=> !rd_en_q) else $error("drive after write/idle"); // R7

  AST_NO_START_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    cke && !adv && !sel |=> !s1_ctl.valid) else $error("access began while deselected"); // R5

  AST_BURST_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    cke && adv && s1_ctl.valid |=> s1_ctl.valid &&
      s1_addr[ADDR_W-1:2] == $past(s1_addr[ADDR_W-1:2]) &&
      s1_ctl.wr == $past(s1_ctl.wr)) else $error("burst left its block"); // R8

  AST_DOUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |=> $stable(dout_q) && $stable(rd_en_q)) else $error("output moved on stall"); // R4

endmodule

// File: tb/tb_zbt_sram.sv
`timescale 1ns/1ps
module tb_zbt_sram;
  localparam int AW = 8;
  localparam int NB = 2;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cke = 1'b1, cs_n_a = 1'b1, cs_b = 1'b0, cs_n_c = 1'b1;
  logic adv = 1'b0, wr = 1'b0, ilv = 1'b0, oe = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [NB-1:0] byte_we = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic dout_oe;

  always #2 clk = ~clk;

  zbt_sram #(.ADDR_W(AW), .NB(NB)) dut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n_a(cs_n_a), .cs_b(cs_b), .cs_n_c(cs_n_c),
    .adv(adv), .wr(wr), .addr(addr), .byte_we(byte_we), .ilv(ilv), .din(din),
    .oe(oe), .dout(dout), .dout_oe(dout_oe)
  );

  int checks = 0, errors = 0;
  string tag = "R12";
  bit done = 0;

  // reference model
  typedef struct { bit v; bit w; int a; int be; } op_t;
  op_t pipe[$];
  int  mdata [256];
  bit  known [256];
  bit  m_act; int m_base; int m_k; bit m_dir;
  bit  exp_en; int exp_dout; bit exp_known;

  always @(posedge clk) begin
    if (!rst_n) begin
      pipe.delete(); m_act = 0; m_k = 0; exp_en = 0; exp_dout = 0; exp_known = 0;
    end else if (cke) begin
      op_t e, n;
      if (pipe.size() == 2) begin
        e = pipe.pop_front();
        exp_en = e.v && !e.w;
        if (e.v && e.w) begin
          for (int b = 0; b < NB; b++)
            if (e.be[b]) begin
              mdata[e.a][8*b +: 8] = din[8*b +: 8];
            end
          if (e.be == 3) known[e.a] = 1;
        end
        if (exp_en) begin exp_dout = mdata[e.a]; exp_known = known[e.a]; end
      end else exp_en = 0;
      n.be = byte_we;
      if (!adv) begin
        n.v = (cs_n_a == 0) && (cs_b == 1) && (cs_n_c == 0);
        n.w = wr; n.a = addr;
        m_act = n.v; m_base = addr; m_k = 0; m_dir = wr;
      end else begin
        n.v = m_act; n.w = m_dir;
        if (m_act) m_k = (m_k + 1) % 4;
        n.a = (m_base & ~3) | (ilv ? ((m_base & 3) ^ m_k) : (((m_base & 3) + m_k) % 4));
      end
      pipe.push_back(n);
    end
  end

  // per-cycle comparison, away from the rising edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (dout_oe !== (exp_en && oe)) begin
        errors++;
        $display("FAIL %s dout_oe actual=%b expected=%b t=%0t", tag, dout_oe, exp_en && oe, $time);
      end
      if (exp_en && exp_known) begin
        checks++;
        if (dout !== exp_dout[DW-1:0]) begin
          errors++;
          $display("FAIL %s dout actual=%h expected=%h t=%0t", tag, dout, exp_dout[DW-1:0], $time);
        end
      end
    end
  end

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // one slot: sel 0 = selected, 1/2/3 = one select inactive
  task automatic slot(input bit a_adv, input bit a_wr, input int a, input int be,
                      input int s = 0, input bit en = 1);
    @(negedge clk); #1;
    cke = en; adv = a_adv; wr = a_wr; addr = a[AW-1:0]; byte_we = be[NB-1:0];
    cs_n_a = (s == 1); cs_b = (s != 2); cs_n_c = (s == 3);
    din = 16'h5A00 ^ DW'(cyc * 16'h0137);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) slot(0, 0, 0, 0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1; tag = "R12";
    checks++;
    if (dout_oe !== 1'b0) begin
      errors++; $display("FAIL R12 dout_oe in reset actual=%b expected=0", dout_oe);
    end
    rst_n = 1;
    @(negedge clk); #1;
    checks++;
    if (dout_oe !== 1'b0) begin
      errors++; $display("FAIL R12 dout_oe after reset actual=%b expected=0", dout_oe);
    end
    idle(2);
    tag = "R2";
    for (int i = 0; i < 32; i++) slot(0, 1, i, 3);
    idle(2);
    tag = "R1";
    for (int i = 31; i >= 0; i--) slot(0, 0, i, 0);
    idle(3);
    tag = "R3";
    for (int i = 0; i < 12; i++) begin
      slot(0, 1, 40 + i, 3);
      slot(0, 0, i, 0);
      slot(0, 0, 40 + i, 0);
    end
    idle(3);
    tag = "R2";
    slot(0, 1, 3, 1); slot(0, 1, 4, 2); slot(0, 1, 5, 0);
    slot(0, 0, 3, 0); slot(0, 0, 4, 0); slot(0, 0, 5, 0);
    idle(3);
    tag = "R4";
    slot(0, 0, 7, 0); slot(0, 1, 8, 3);
    for (int i = 0; i < 5; i++) slot(i[0], 1, 9 + i, 3, 0, 0);
    slot(0, 0, 8, 0); slot(0, 0, 9, 0);
    for (int i = 0; i < 3; i++) slot(0, 0, 20, 0, 0, 0);
    slot(0, 0, 10, 0); slot(0, 0, 11, 0);
    idle(3);
    tag = "R5";
    for (int s = 1; s <= 3; s++) begin
      slot(0, 1, 6, 3, s); slot(1, 1, 6, 3, s); slot(0, 0, 6, 0, s);
    end
    slot(0, 0, 6, 0); idle(3);
    tag = "R6";
    slot(0, 0, 12, 0); slot(0, 1, 13, 3); idle(1); slot(0, 0, 13, 0); idle(3);
    tag = "R7";
    slot(0, 0, 14, 0); slot(0, 0, 15, 0); slot(0, 1, 16, 3); slot(0, 0, 17, 0);
    idle(1); slot(0, 0, 18, 0); idle(3);
    tag = "R9";
    ilv = 0;
    slot(0, 0, 5, 0); for (int i = 0; i < 3; i++) slot(1, 0, 0, 0);
    slot(0, 0, 14, 0); for (int i = 0; i < 3; i++) slot(1, 0, 0, 0);
    idle(3);
    tag = "R8";
    slot(0, 0, 22, 0); for (int i = 0; i < 6; i++) slot(1, 1, 0, 0);
    slot(0, 1, 60, 3); for (int i = 0; i < 3; i++) slot(1, 0, 0, 3);
    idle(2);
    for (int i = 60; i < 64; i++) slot(0, 0, i, 0);
    idle(3);
    tag = "R10";
    ilv = 1;
    slot(0, 0, 9, 0); for (int i = 0; i < 3; i++) slot(1, 0, 0, 0);
    slot(0, 1, 70, 3); for (int i = 0; i < 3; i++) slot(1, 0, 0, 3);
    slot(0, 0, 71, 0); for (int i = 0; i < 3; i++) slot(1, 0, 0, 0);
    idle(3);
    ilv = 0;
    for (int i = 68; i < 72; i++) slot(0, 0, i, 0);
    idle(3);
    tag = "R11";
    for (int i = 0; i < 10; i++) begin
      slot(0, 0, i, 0);
      oe = i[1];
    end
    oe = 1;
    idle(3);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired in %s", tag);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule